// File: doc/BRIEF.md
# USB line-state clock recovery

This block recovers bit timing from an oversampled USB D+/D- pair at low or full speed. The two line inputs pass through a synchroniser and are decoded each sample clock into one of four line symbols. While idle the block watches for a J-to-K change. Once it sees one, a fractional position accumulator places a strobe near the middle of every following bit cell.

On every data transition the loop checks the symbol it latched half a bit period before the strobe position. It uses that symbol to shorten or lengthen the bit period and to pull the strobe phase earlier or later. This lets the strobe follow a transmitter whose rate differs slightly from the nominal samples-per-bit value. The outputs are a one-cycle strobe per recovered bit, together with the symbol sampled at that strobe. Packet framing and NRZI decoding belong to the logic downstream.

The nominal samples-per-bit value is an unsigned fixed-point number with 16 fractional bits (8.0 is 0x080000). The bit period and the strobe position use the same format.

Top module: `usb_clk_recover`

## Requirements
- R1: Symbol codes on `sym_out`: J=0, K=1, SE0=2, SE1=3. {D+,D-}=00 decodes to SE0 and 11 decodes to SE1. With `low_speed`=0, 10 is J and 01 is K. With `low_speed`=1 these two are swapped.
- R2: Each line input passes through two synchroniser flops before decoding. A level driven on the pins in clock n therefore reaches the registered outputs after the clock edge that ends clock n+2.
- R3: While idle, a decoded J followed in the next sample by a decoded K starts tracking. `track_active` rises and the speed in force is latched.
- R4: If the K of the start condition is sample s, the first strobe falls on sample floor(s + P/2 + 1/2), where P is the nominal period and P/2 is truncated to 16 fractional bits.
- R5: Each later strobe falls on sample floor(x), where x is the previous strobe position plus the current period (after any adjustment). `bit_strobe` is a single-cycle pulse. `sym_out` carries the symbol taken at that strobe and holds it until the next strobe. The nominal period must be at least 4.0.
- R6: The line symbol is latched in sample floor(x - P/2) before each strobe position x, where P is the current period. Consider a strobe whose J or K symbol differs from the previous strobe's symbol. If the latched boundary symbol already equals the new symbol, P becomes P - (P>>10) and the position moves earlier by P>>7 (taken from the new P). For the first bit the boundary symbol is K.
- R7: In the same transition case, if the boundary symbol differs from the new symbol, P becomes P + (P>>10) and the position moves later by P>>7 (taken from the new P).
- R8: No adjustment is made in any of these cases: the boundary symbol is SE0 or SE1, the symbol has not changed, or tracking is in its end phase.
- R9: A strobe that samples SE0 enters the end phase. In the end phase, a strobe that samples J right after a strobe that sampled SE0 ends tracking and restores the period to nominal.
- R10: A strobe that samples SE1 still pulses `bit_strobe` with `sym_out`=3. It also raises `line_err` for one cycle and returns the block to idle.
- R11: A change of `low_speed` while tracking raises `line_err` for one cycle and returns the block to idle. No strobe is issued in that cycle.
- R12: After reset `bit_strobe`, `line_err` and `track_active` are 0 and `sym_out` is 0 (J).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dp_in | input | 1 | D+ line level |
| dm_in | input | 1 | D- line level |
| low_speed | input | 1 | 1 selects low-speed polarity, 0 selects full speed |
| nom_period | input | INT_W+FRAC | Nominal samples per bit, FRAC fractional bits |
| bit_strobe | output | 1 | One-cycle pulse per recovered bit |
| sym_out | output | 2 | Line symbol taken at the latest strobe |
| track_active | output | 1 | High while bit timing is being tracked |
| line_err | output | 1 | One-cycle pulse on SE1 or a speed change while tracking |

## Verification
Every result of this block is due three clock edges after the pin level that causes it: two synchroniser stages, then the registered decision. The bench drives pins on falling edges and keeps a history of every driven level and speed setting. At each falling edge it advances an arithmetic model of the strobe position, period and boundary symbol by the sample driven three cycles earlier, and compares all four outputs with that model. The strobe cycle, period steps, end phase and error cases are therefore each checked in the exact cycle they become visible. The sweeps cover both speeds, nominal periods below, at and above the true bit length, an SE0 glitch near a boundary, an SE1 burst and a speed change in mid-packet.

// File: rtl/usb_cr_pkg.sv
package usb_cr_pkg;
   // Decoded line state; codes are visible on the top-level symbol output.
   typedef enum logic [1:0] {
      SYM_J   = 2'd0,
      SYM_K   = 2'd1,
      SYM_SE0 = 2'd2,
      SYM_SE1 = 2'd3
   } line_sym_t;
endpackage

// File: rtl/usb_cr_sync.sv
module usb_cr_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("usb_cr_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/usb_cr_decode.sv
module usb_cr_decode
   import usb_cr_pkg::*;
(
   input  logic      dp,
   input  logic      dm,
   input  logic      low_speed,
   output line_sym_t sym
);
   // R1: single-ended states are speed independent, J/K swap with speed
   always_comb begin
      unique case ({dp, dm})
         2'b00:   sym = SYM_SE0;
         2'b11:   sym = SYM_SE1;
         2'b10:   sym = low_speed ? SYM_K : SYM_J;
         default: sym = low_speed ? SYM_J : SYM_K;
      endcase
   end
endmodule

// File: rtl/usb_cr_track.sv
module usb_cr_track
   import usb_cr_pkg::*;
#(
   parameter int FRAC   = 16,
   parameter int PW     = 24,
   parameter int SH_PER = 10,
   parameter int SH_PH  = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  line_sym_t     line,
   input  logic          low_speed,
   input  logic [PW-1:0] nom_period,
   output logic          strobe,
   output line_sym_t     sym,
   output logic          err,
   output logic          active
);
   localparam int RW = PW + 2;
   localparam logic signed [RW-1:0] ONE  = RW'(1) << FRAC;
   localparam logic signed [RW-1:0] HALF = RW'(1) << (FRAC - 1);

   logic                 active_q, spd_q, eop_q, strobe_q, err_q;
   logic [PW-1:0]        per_q, per_n, step;
   logic signed [RW-1:0] rem_q, rem_adv, bnd, rem_sop;
   line_sym_t            prev_q, edge_q, line_prev_q, sym_q;
   logic                 fire, cap, sop, spd_err, se1_hit, end_pkt, adj, early;

   always_comb begin
      // rem_q: distance from the current sample to the next strobe position
      fire    = active_q && (rem_q < ONE);
      bnd     = rem_q - $signed({2'b00, per_q >> 1});
      cap     = active_q && !bnd[RW-1] && (bnd < ONE);
      sop     = !active_q && (line_prev_q == SYM_J) && (line == SYM_K);
      spd_err = active_q && (low_speed != spd_q);
      se1_hit = fire && (line == SYM_SE1);
      end_pkt = fire && eop_q && (prev_q == SYM_SE0) && (line == SYM_J);
      adj     = fire && !eop_q && ((line == SYM_J) || (line == SYM_K)) &&
                (line != prev_q) && ((edge_q == SYM_J) || (edge_q == SYM_K));
      early   = (edge_q == line);
      per_n   = per_q;
      if (adj) per_n = early ? per_q - (per_q >> SH_PER) : per_q + (per_q >> SH_PER);
      step    = adj ? (per_n >> SH_PH) : '0;
      rem_adv = rem_q - ONE + $signed({2'b00, per_n});
      if (adj && early) rem_adv = rem_adv - $signed({2'b00, step});
      else if (adj)     rem_adv = rem_adv + $signed({2'b00, step});
      rem_sop = $signed({2'b00, nom_period >> 1}) + HALF - ONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q    <= 1'b0;
         spd_q       <= 1'b0;
         eop_q       <= 1'b0;
         per_q       <= '0;
         rem_q       <= '0;
         prev_q      <= SYM_J;
         edge_q      <= SYM_J;
         line_prev_q <= SYM_SE0;
         sym_q       <= SYM_J;
         strobe_q    <= 1'b0;
         err_q       <= 1'b0;
      end else begin
         line_prev_q <= line;
         strobe_q    <= fire && !spd_err;
         err_q       <= spd_err || se1_hit;
         if (fire && !spd_err) sym_q <= line;
         if (!active_q) begin
            per_q <= nom_period;
            if (sop) begin
               active_q <= 1'b1;
               spd_q    <= low_speed;
               rem_q    <= rem_sop;
               prev_q   <= SYM_J;
               edge_q   <= SYM_K;
               eop_q    <= 1'b0;
            end
         end else if (spd_err || se1_hit || end_pkt) begin
            active_q <= 1'b0;
            per_q    <= nom_period;
         end else begin
            if (cap) edge_q <= line;
            if (fire) begin
               per_q  <= per_n;
               rem_q  <= rem_adv;
               prev_q <= line;
               if (line == SYM_SE0) eop_q <= 1'b1;
            end else begin
               rem_q <= rem_q - ONE;
            end
         end
      end
   end

   assign strobe = strobe_q;
   assign sym    = sym_q;
   assign err    = err_q;
   assign active = active_q;

   // R5: the period only moves in a strobe cycle
   p_period_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && $past(active_q) && (per_q != $past(per_q))) |-> $past(fire));

   // R6: a shrinking period shrinks by exactly one step
   p_period_shrink_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && $past(active_q) && (per_q < $past(per_q))) |->
      (per_q == $past(per_q) - ($past(per_q) >> SH_PER)));

   // R7: a growing period grows by exactly one step
   p_period_grow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && $past(active_q) && (per_q > $past(per_q))) |->
      (per_q == $past(per_q) + ($past(per_q) >> SH_PER)));

   // R9: while idle the period follows the nominal input
   p_idle_nominal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && $past(!active_q) && $past(rst_n)) |-> (per_q == $past(nom_period)));
endmodule

// File: rtl/usb_clk_recover.sv
module usb_clk_recover
   import usb_cr_pkg::*;
#(
   parameter int FRAC        = 16,
   parameter int INT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int SH_PER      = 10,
   parameter int SH_PH       = 7,
   localparam int PW         = INT_W + FRAC
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dp_in,
   input  logic          dm_in,
   input  logic          low_speed,
   input  logic [PW-1:0] nom_period,
   output logic          bit_strobe,
   output logic [1:0]    sym_out,
   output logic          track_active,
   output logic          line_err
);
   generate
      if (FRAC < SH_PER || FRAC < SH_PH) begin : g_bad_frac
         $error("FRAC must cover both adjustment shifts");
      end
      if (INT_W < 3) begin : g_bad_int
         $error("INT_W must hold a period of at least 4 samples");
      end
   endgenerate

   logic [1:0] pins_s;
   line_sym_t  line_sym, trk_sym;

   usb_cr_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({dp_in, dm_in}),
      .q     (pins_s)
   );

   usb_cr_decode u_dec (
      .dp        (pins_s[1]),
      .dm        (pins_s[0]),
      .low_speed (low_speed),
      .sym       (line_sym)
   );

   usb_cr_track #(.FRAC(FRAC), .PW(PW), .SH_PER(SH_PER), .SH_PH(SH_PH)) u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .line       (line_sym),
      .low_speed  (low_speed),
      .nom_period (nom_period),
      .strobe     (bit_strobe),
      .sym        (trk_sym),
      .err        (line_err),
      .active     (track_active)
   );

   assign sym_out = trk_sym;

   // R5: strobes never come back to back
   p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_strobe |=> !bit_strobe);

   // R10: an error always leaves the block idle
   p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      line_err |-> !track_active);

   // R10: a strobe carrying SE1 flags an error
   p_se1_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_strobe && (sym_out == 2'd3)) |-> line_err);
endmodule

// File: tb/sim_usb_clk_recover.sv
module sim_usb_clk_recover;
   localparam int PW   = 24;
   localparam int NMAX = 16384;
   localparam longint ONE = 64'sd65536;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0, dp = 1'b0, dm = 1'b0, ls = 1'b0, ls_next = 1'b0;
   logic [PW-1:0] nom = 24'h080000;
   logic          bit_strobe, track_active, line_err;
   logic [1:0]    sym_out;

   usb_clk_recover u0 (
      .clk(clk), .rst_n(rst_n), .dp_in(dp), .dm_in(dm), .low_speed(ls),
      .nom_period(nom), .bit_strobe(bit_strobe), .sym_out(sym_out),
      .track_active(track_active), .line_err(line_err)
   );

   int checks = 0, errors = 0, j = 0;
   bit done = 1'b0;
   logic [1:0] h_pins [NMAX];
   logic       h_ls   [NMAX];

   // reference model state
   bit m_act = 0, m_ls = 0, m_eop = 0, m_first = 0, e_str = 0, e_err = 0;
   int m_per = 0;
   longint m_pos = 0;
   logic [1:0] m_prev = 0, m_edge = 0, m_line = 2, m_sym = 0;
   string tag = "R12";

   function automatic logic [1:0] dec(input logic [1:0] p, input logic l);
      case (p)
         2'b00:   return 2'd2;
         2'b11:   return 2'd3;
         2'b10:   return l ? 2'd1 : 2'd0;
         default: return l ? 2'd0 : 2'd1;
      endcase
   endfunction

   function automatic logic [1:0] pins_of(input logic [1:0] s, input logic l);
      case (s)
         2'd0:    return l ? 2'b01 : 2'b10;
         2'd1:    return l ? 2'b10 : 2'b01;
         2'd2:    return 2'b00;
         default: return 2'b11;
      endcase
   endfunction

   task automatic model_step(input int c);
      logic [1:0] s, old_edge;
      logic sp;
      int stp;
      sp = h_ls[c+2];
      s  = dec(h_pins[c], sp);
      e_str = 0; e_err = 0; tag = "R3";
      if (!m_act) begin
         m_per = int'(nom);
         if (m_line == 2'd0 && s == 2'd1) begin
            m_act = 1; m_ls = sp; m_eop = 0; m_first = 1;
            m_pos = longint'(c) * ONE + longint'(nom >> 1) + ONE / 2;
            m_prev = 2'd0; m_edge = 2'd1; tag = "R2 R3";
         end
      end else if (sp != m_ls) begin
         e_err = 1; m_act = 0; m_per = int'(nom); tag = "R11";
      end else begin
         old_edge = m_edge;
         if (((m_pos - longint'(m_per >> 1)) >>> 16) == longint'(c)) m_edge = s;
         if ((m_pos >>> 16) == longint'(c)) begin
            e_str = 1; m_sym = s;
            tag = m_first ? "R1 R4" : "R1 R5";
            m_first = 0;
            if (s == 2'd3) begin
               e_err = 1; m_act = 0; m_per = int'(nom); tag = "R10";
            end else if (m_eop && m_prev == 2'd2 && s == 2'd0) begin
               m_act = 0; m_per = int'(nom); tag = "R9";
            end else begin
               stp = 0;
               if (!m_eop && s < 2 && s != m_prev && old_edge < 2) begin
                  if (old_edge == s) begin
                     m_per = m_per - (m_per >> 10); stp = -(m_per >> 7); tag = "R6 R4";
                  end else begin
                     m_per = m_per + (m_per >> 10); stp = m_per >> 7; tag = "R7";
                  end
               end else if (s == 2'd2) begin
                  m_eop = 1; tag = "R9 R8";
               end else begin
                  tag = "R1 R8";
               end
               m_pos = m_pos + longint'(m_per) + longint'(stp);
               m_prev = s;
            end
         end
      end
      m_line = s;
   endtask

   task automatic compare();
      checks++;
      if (bit_strobe !== e_str || line_err !== e_err || track_active !== m_act || sym_out !== m_sym) begin
         errors++;
         $display("FAIL %s cycle %0d: got strobe=%0b err=%0b active=%0b sym=%0d, expected strobe=%0b err=%0b active=%0b sym=%0d",
                  tag, j, bit_strobe, line_err, track_active, sym_out, e_str, e_err, m_act, m_sym);
      end
   endtask

   task automatic drv(input logic [1:0] s, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (j >= NMAX) return;
         rst_n = 1'b1;
         ls = ls_next;
         {dp, dm} = pins_of(s, ls_next);
         h_pins[j] = {dp, dm};
         h_ls[j] = ls;
         if (j >= 3) model_step(j - 3);
         else begin e_str = 0; e_err = 0; tag = "R12"; end
         compare();
         j++;
      end
   endtask

   task automatic pkt(input int blen, input int nbits, input logic [7:0] seed);
      logic [7:0] lf;
      logic [1:0] lvl;
      lf = seed;
      drv(2'd0, 6);
      lvl = 2'd1;
      drv(lvl, blen);
      for (int b = 0; b < nbits; b++) begin
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         if (!lf[0]) lvl = (lvl == 2'd0) ? 2'd1 : 2'd0;
         drv(lvl, blen);
      end
      drv(2'd2, 2 * blen);
      drv(2'd0, 3 * blen);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got hung run, expected completion");
         summary();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R12: outputs while reset is held
      checks++;
      if (bit_strobe !== 1'b0 || line_err !== 1'b0 || track_active !== 1'b0 || sym_out !== 2'd0) begin
         errors++;
         $display("FAIL R12: got %0b%0b%0b sym=%0d, expected 000 sym=0",
                  bit_strobe, line_err, track_active, sym_out);
      end
      // R1 R4 R5 R6 R7 R8 R9: both speeds, nominal 7.0 to 9.0 against 8-sample bits
      for (int l = 0; l < 2; l++) begin
         ls_next = l[0];
         drv(2'd0, 4);
         for (int k = 0; k < 5; k++) begin
            nom = 24'h070000 + 24'(k) * 24'h008000;
            pkt(8, 20, 8'(8'h5a + k + 16 * l));
         end
      end
      ls_next = 1'b0;
      nom = 24'h060000;
      pkt(6, 24, 8'hc3);
      nom = 24'h0a0000;
      pkt(10, 16, 8'h37);
      // R8: SE0 glitch next to a bit boundary
      nom = 24'h080000;
      drv(2'd0, 6); drv(2'd1, 8); drv(2'd0, 8); drv(2'd2, 1); drv(2'd0, 7);
      drv(2'd1, 8); drv(2'd0, 4); drv(2'd2, 1); drv(2'd1, 11); drv(2'd2, 16); drv(2'd0, 24);
      // R10: SE1 burst in mid-packet
      drv(2'd0, 6); drv(2'd1, 8); drv(2'd0, 8); drv(2'd1, 8); drv(2'd3, 12); drv(2'd0, 12);
      // R11: speed change while tracking, then back in idle
      drv(2'd0, 6); drv(2'd1, 8); drv(2'd0, 8);
      ls_next = 1'b1;
      drv(2'd1, 8); drv(2'd0, 12);
      ls_next = 1'b0;
      drv(2'd0, 12);
      pkt(8, 12, 8'h99);
      drv(2'd0, 8);
      summary();
   end
endmodule